// File: doc/BRIEF.md
# Cascadable Timer Pair with Compare Output

This block holds two up-counting timers, a lower one and an upper one, each `TW` bits wide. Each timer counts ticks from its own clock source. A 3-bit select field chooses that source: one of seven power-of-two divisions of the system clock, or rising edges on an external count pin. Each timer compares its count against a data register. On a match the count returns to zero and a sticky interrupt flag is raised.

A cascade bit in the lower timer's mode register joins the two timers into one counter of `2*TW` bits. The upper count forms the high half, and it is compared against the two data registers joined in the same order. In cascade mode the lower timer's select and run control drive the joined counter, and only the lower flag can fire. A compare output toggles on every lower (or joined) match while it is enabled. This gives a square wave with a 50% duty cycle at a frequency of clk / (2 × divide × (data + 1)).

Software programs the block through a write-only register port. Address 0 is the lower timer's mode register and address 1 is the upper timer's. Addresses 2 and 3 are the lower and upper data registers. Address 4 clears the flags.

Top module: `cascade_timer`

## Requirements
- R1: Mode bits [2:0] select the divide ratio: 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16, 100 gives 64, 101 gives 256 and 110 gives 1024. After a start write at edge W, with data D and divide P, matches occur at edges W + P×(D+1)×k.
- R2: Select value 111 advances the count once per rising edge of `ext_clk_i`. The edge passes through a two-stage synchroniser, so it is counted at the third clock edge after the pin rises.
- R3: A mode write with bit 3 (start) set clears the count and the divider and starts the timer. A mode write with bits 4 and 3 both 0 stops the timer, and the count holds.
- R4: A mode write with bit 3 clear and bit 4 (continue) set resumes counting from the held count and divider state.
- R5: A tick that finds the count equal to the data register returns the count to zero and sets the timer's flag. Any other tick increments the count.
- R6: When bit 5 of the lower mode register (cascade) is set, the count {upper, lower} advances on the lower timer's ticks. It matches against {data upper, data lower}, and a match clears both halves.
- R7: While cascade is set, `irq_hi` never rises, even if the upper timer is running.
- R8: When bit 6 of the lower mode register is set, `cmp_out` toggles on each lower or joined match. When that bit is clear, `cmp_out` holds.
- R9: Flags stay set until software writes 1 to address 4: bit 0 clears `irq_lo` and bit 1 clears `irq_hi`. A match in the same cycle as a clear leaves the flag set.
- R10: Reset leaves both mode registers at zero, so both timers are stopped. It also clears both counts, both flags and `cmp_out`, and sets both data registers to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 lower mode, 1 upper mode, 2 lower data, 3 upper data, 4 flag clear |
| wr_data | input | TW | Register write data |
| irq_lo | output | 1 | Lower (or joined) timer match flag |
| irq_hi | output | 1 | Upper timer match flag |
| cmp_out | output | 1 | Compare toggle output |

## Verification
The bench builds the block with TW = 8 and SYNC = 2. With these values every divide ratio, including 1024, produces two matches within a few thousand cycles. The joined 16-bit compare can be reached with an upper data byte of 1, so a match above the 8-bit range arrives after about 500 cycles. With the shortest ratio and a data value of zero, a match falls on every second clock edge. This lets the bench place a flag-clear write on exactly the edge of a match. Fixing the synchroniser depth at two also fixes the external-pin latency at three edges, so the bench can predict exact cycle numbers for pin-driven matches.

// File: rtl/cascade_timer.sv
`timescale 1ns/1ps
module cascade_timer #(
  parameter int TW = 8,
  parameter int SYNC = 2,
  parameter logic [TW-1:0] DATA_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk_i,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [TW-1:0] wr_data,
  output logic          irq_lo,
  output logic          irq_hi,
  output logic          cmp_out
);
  localparam int PW = 10;
  localparam int CW = 2 * TW;

  logic [1:0][2:0]    csel;
  logic               casc, oe;
  logic [1:0]         run, tick, wmode, wdata;
  logic [1:0][TW-1:0] cnt, dat;
  logic [1:0][PW-1:0] pre;
  logic [SYNC:0]      sh;
  logic               ext_rise, wclr, match_lo, match_hi;
  logic               wr_unused;

  function automatic logic [PW-1:0] div_mask(input logic [2:0] s);
    case (s)
      3'd0:    return PW'(1);
      3'd1:    return PW'(3);
      3'd2:    return PW'(7);
      3'd3:    return PW'(15);
      3'd4:    return PW'(63);
      3'd5:    return PW'(255);
      default: return PW'(1023);
    endcase
  endfunction

  assign wr_unused = &{1'b0, wr_data[TW-1:7]};
  assign ext_rise  = sh[SYNC-1] & ~sh[SYNC];
  assign wclr      = wr_en && (wr_addr == 3'd4);

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    logic [PW-1:0] m;
    assign m        = div_mask(csel[i]);
    assign tick[i]  = run[i] & ((csel[i] == 3'b111) ? ext_rise : ((pre[i] & m) == m));
    assign wmode[i] = wr_en && (wr_addr == 3'(i));
    assign wdata[i] = wr_en && (wr_addr == 3'(i + 2));
  end

  assign match_lo = tick[0] & (casc ? (cnt == dat) : (cnt[0] == dat[0]));
  assign match_hi = tick[1] & ~casc & (cnt[1] == dat[1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], ext_clk_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel    <= '0;
      casc    <= 1'b0;
      oe      <= 1'b0;
      run     <= '0;
      cnt     <= '0;
      dat     <= {2{DATA_RST}};
      pre     <= '0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
      cmp_out <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (run[i]) pre[i] <= pre[i] + PW'(1);

      if (casc) begin
        if (tick[0]) cnt <= match_lo ? '0 : cnt + CW'(1);
      end else begin
        for (int i = 0; i < 2; i++)
          if (tick[i]) cnt[i] <= (cnt[i] == dat[i]) ? '0 : cnt[i] + TW'(1);
      end

      for (int i = 0; i < 2; i++)
        if (wmode[i]) begin
          csel[i] <= wr_data[2:0];
          run[i]  <= wr_data[3] | wr_data[4];
          if (wr_data[3]) begin
            cnt[i] <= '0;
            pre[i] <= '0;
          end
        end

      if (wmode[0]) begin
        casc <= wr_data[5];
        oe   <= wr_data[6];
        if (wr_data[3] && wr_data[5]) cnt[1] <= '0;
      end

      for (int i = 0; i < 2; i++)
        if (wdata[i]) dat[i] <= wr_data;

      irq_lo  <= match_lo | (irq_lo & ~(wclr & wr_data[0]));
      irq_hi  <= match_hi | (irq_hi & ~(wclr & wr_data[1]));
      cmp_out <= cmp_out ^ (match_lo & oe);
    end
  end
endmodule

module cascade_timer_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          casc,
  input logic          oe,
  input logic          irq_lo,
  input logic          irq_hi,
  input logic          cmp_out,
  input logic [TW-1:0] cnt_lo,
  input logic          lo_wr,
  input logic          lo_start,
  input logic          lo_cont,
  input logic          clr_lo,
  input logic          clr_hi
);
  a_r7_hi_quiet_in_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> !$past(casc));

  a_r9_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_lo) |-> $past(clr_lo));

  a_r9_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_hi) |-> $past(clr_hi));

  a_r8_toggle_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_out) |-> ($past(oe) && irq_lo));

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && lo_start) |=> (cnt_lo == '0));

  a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !lo_start && !lo_cont) ##1 !lo_wr |=> $stable(cnt_lo));
endmodule

bind cascade_timer cascade_timer_chk #(.TW(TW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .casc     (casc),
  .oe       (oe),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .cmp_out  (cmp_out),
  .cnt_lo   (cnt[0]),
  .lo_wr    (wmode[0]),
  .lo_start (wr_data[3]),
  .lo_cont  (wr_data[4]),
  .clr_lo   (wclr & wr_data[0]),
  .clr_hi   (wclr & wr_data[1])
);

// File: tb/cascade_timer_bench.sv
`timescale 1ns/1ps
module cascade_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0, ext_pin = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_lo, irq_hi, cmp_out;

  cascade_timer #(.TW(8), .SYNC(2)) u_cascade_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .cmp_out(cmp_out));

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  typedef struct { int unsigned at; string tag; } ev_t;
  ev_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push(input int unsigned at, input string tag);
    ev_t e;
    e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  logic last_out = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (cmp_out !== last_out)) begin
      last_out = cmp_out;
      if (exp_q.size() == 0) check(1'b0, "R8", "unexpected toggle cycle", cyc, 0);
      else begin
        ev_t e;
        e = exp_q.pop_front();
        check(cyc == e.at, e.tag, "toggle cycle", cyc, e.at);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d, output int unsigned at);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    at = cyc;
    wr_en = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  function automatic logic [7:0] md(input logic [2:0] cs, input bit st, input bit co,
                                    input bit ca, input bit en);
    return {1'b0, en, ca, co, st, cs};
  endfunction

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    check(1'b0, "R1", "watchdog cycle", cyc, 0);
    finish_up();
  end

  initial begin
    int unsigned w, x, c, r;
    logic held;
    int shv[7] = '{1, 2, 3, 4, 6, 8, 10};
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state
    check(irq_lo == 1'b0, "R10", "irq_lo after reset", irq_lo, 0);
    check(irq_hi == 1'b0, "R10", "irq_hi after reset", irq_hi, 0);
    check(cmp_out == 1'b0, "R10", "cmp_out after reset", cmp_out, 0);
    idle(100);
    // R10 data resets to all ones: first match after 2*256
    wreg(3'd0, md(3'd0, 1, 0, 0, 1), w);
    push(w + 512, "R10");
    drain();
    wreg(3'd0, md(3'd0, 0, 0, 0, 1), w);

    // R1 every divide ratio with data 1
    wreg(3'd2, 8'd1, w);
    for (int s = 0; s < 7; s++) begin
      wreg(3'd0, md(3'(s), 1, 0, 0, 1), w);
      push(w + (1 << shv[s]) * 2, "R1");
      push(w + (1 << shv[s]) * 4, "R1");
      drain();
      wreg(3'd0, md(3'(s), 0, 0, 0, 1), w);
    end

    // R5 data 3, divide 4
    wreg(3'd2, 8'd3, w);
    wreg(3'd0, md(3'd1, 1, 0, 0, 1), w);
    push(w + 16, "R5"); push(w + 32, "R5"); push(w + 48, "R5");
    drain();
    wreg(3'd0, md(3'd1, 0, 0, 0, 1), w);
    check(irq_lo == 1'b1, "R5", "irq_lo after match", irq_lo, 1);

    // R9 clear, then clear colliding with a match
    wreg(3'd4, 8'h01, w);
    check(irq_lo == 1'b0, "R9", "irq_lo after clear", irq_lo, 0);
    held = cmp_out;
    wreg(3'd2, 8'd0, w);
    wreg(3'd0, md(3'd0, 1, 0, 0, 0), w);
    idle(3);
    wreg(3'd4, 8'h01, x);
    check(x == w + 4, "R9", "clear edge", x, w + 4);
    check(irq_lo == 1'b1, "R9", "set wins over clear", irq_lo, 1);
    wreg(3'd4, 8'h01, x);
    check(irq_lo == 1'b0, "R9", "clear between matches", irq_lo, 0);
    wreg(3'd0, md(3'd0, 0, 0, 0, 0), w);
    check(cmp_out == held, "R8", "cmp_out with output disabled", cmp_out, held);

    // R3 stop and R4 continue
    wreg(3'd2, 8'd9, w);
    wreg(3'd0, md(3'd0, 1, 0, 0, 1), w);
    idle(6);
    wreg(3'd0, md(3'd0, 0, 0, 0, 1), x);
    check(x == w + 7, "R3", "stop edge", x, w + 7);
    idle(50);
    wreg(3'd0, md(3'd0, 0, 1, 0, 1), c);
    push(c + 13, "R4");
    push(c + 33, "R4");
    drain();
    wreg(3'd0, md(3'd0, 1, 0, 0, 1), w);
    push(w + 20, "R3");
    drain();
    wreg(3'd0, md(3'd0, 0, 0, 0, 1), w);

    // R2 external pin, data 2: match on every third rise
    wreg(3'd2, 8'd2, w);
    wreg(3'd0, md(3'd7, 1, 0, 0, 1), w);
    idle(2);
    for (int k = 1; k <= 6; k++) begin
      ext_pin = 1'b1;
      r = cyc;
      if (k % 3 == 0) push(r + 3, "R2");
      idle(3);
      ext_pin = 1'b0;
      idle(4);
    end
    drain();
    wreg(3'd0, md(3'd7, 0, 0, 0, 1), w);
    for (int k = 0; k < 3; k++) begin
      ext_pin = 1'b1; idle(3); ext_pin = 1'b0; idle(3);
    end

    // R6 joined count 0x0102 with upper running on its own, R7 quiet upper flag
    wreg(3'd4, 8'h03, w);
    wreg(3'd3, 8'd1, w);
    wreg(3'd2, 8'd2, w);
    wreg(3'd1, md(3'd0, 1, 0, 0, 0), w);
    wreg(3'd0, md(3'd0, 1, 0, 1, 1), w);
    push(w + 518, "R6");
    push(w + 1036, "R6");
    drain();
    check(irq_lo == 1'b1, "R6", "irq_lo after joined match", irq_lo, 1);
    check(irq_hi == 1'b0, "R7", "irq_hi in cascade", irq_hi, 0);
    wreg(3'd0, md(3'd0, 0, 0, 0, 1), w);
    idle(10);
    check(irq_hi == 1'b1, "R7", "irq_hi once cascade off", irq_hi, 1);
    wreg(3'd1, md(3'd0, 0, 0, 0, 0), w);

    idle(20);
    check(exp_q.size() == 0, "R1", "pending expected toggles", exp_q.size(), 0);
    finish_up();
  end
endmodule